// File: doc/BRIEF.md
# SPI serial memory slave front-end

This block is the serial side of a small nonvolatile-style memory. It acts only as a slave. It listens on a mode-0 SPI link: data in on one pin, data out on a separate pin that has its own drive enable. The SPI pins are asynchronous to the block's system clock. The system clock runs well above the serial clock, and the block resynchronises every pin and works on the detected edges. After the chip select goes low, the first byte is an opcode. Depending on that opcode, the block toggles the write-enable latch, returns the status byte, updates the protection bit of the status register, or reads or writes a small internal byte array through a 16-bit address.

A hold input can suspend a transfer half way through without losing its place. An opcode the block does not accept silences the slave until the next select. A write-protect pin, together with an enable bit in the status register, can block status-register updates. A committed write sets a busy flag for a fixed number of system clocks.

Top module: `spimem_slave`

## Requirements
- R1: While chip select is high, the output enable stays 0, and serial clock or input activity changes no state.
- R2: The first byte after chip select falls is decoded as the opcode: 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write. Read status returns {wpen, 5'b0, wel, busy}, with busy in bit 0, wel in bit 1 and wpen in bit 7, repeated for as long as the master clocks.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R4: A read takes a 16-bit address, MSB first, and then returns bytes MSB first. The output changes only after a falling serial clock edge, and input is sampled on the rising edge. The address increments after each byte. Only the low log2(DEPTH) address bits select a byte.
- R5: A write stores the last complete data byte at the given address. It does so only if the write-enable latch is set, at least one data byte arrived, and chip select rises on a byte boundary. Otherwise the array is unchanged.
- R6: A commit sets the busy flag (status bit 0) for BUSY_CYCLES system clocks and clears the write-enable latch.
- R7: While busy, every opcode except read status is handled as invalid (see R8). In particular, 0x06 does not set the latch.
- R8: After an invalid opcode, the block accepts no further bytes and keeps the output enable at 0 until the next falling edge of chip select.
- R9: Hold engages or releases only while the serial clock is low. While held, the output enable is 0 and clock and input edges are ignored. The transfer continues where it left off once hold is released.
- R10: Write status updates only bit 7 (wpen) and needs the write-enable latch. It is refused when the protect pin is low and wpen is 1, and in that case the latch stays set.
- R11: When wpen is 0, the protect pin has no effect, so write status works with the pin held low.
- R12: If the protect pin goes low while a write-status command is selected and wpen is 1, that command is cancelled, even if the pin returns high before chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_wp_n | input | 1 | Active-low status write protect |
| spi_miso | output | 1 | Serial data out (0 when not driven) |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |

## Verification
The checks assume that every SPI pin holds steady for at least several system clocks around each change. This lets the synchronisers deliver clean edges, and it keeps hold changes and clock edges apart. The stimulus therefore holds each serial clock phase for eight system clocks. It changes the hold pin only while the serial clock has been low for some time, and it waits after each select change before it clocks. The busy checks assume the master does not finish a whole command frame within BUSY_CYCLES. The bench waits out the countdown explicitly rather than polling.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
    localparam int ADDR_BITS = 16;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRIT = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADDR, PH_DATA, PH_LOCK
    } phase_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRIT
    } cmd_t;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int STAGES = 2,
    parameter int N = 5,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[i]};
        end
        assign sync_o[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int DEPTH = 64,
    localparam int MW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [MW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [MW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spimem_core.sv
module spimem_core
    import spimem_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int BUSY_CYCLES = 2000,
    localparam int MW = $clog2(DEPTH),
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          cs_s,
    input  logic          mosi_s,
    input  logic          hold_s,
    input  logic          wp_s,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic [MW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [MW-1:0] mem_raddr,
    output logic          miso,
    output logic          miso_oe,
    output logic          held,
    output logic          locked,
    output logic          busy,
    output logic          wel
);
    typedef struct packed {
        phase_t                 phase;
        cmd_t                   cmd;
        logic [2:0]             bitcnt;
        logic [6:0]             sh;
        logic [ADDR_BITS-1:0]   addr;
        logic                   abyte;
        logic                   load;
        logic [7:0]             osr;
        logic                   miso;
        logic                   held;
        logic                   sck_p;
        logic                   cs_p;
        logic                   wel;
        logic                   wpen;
        logic [CW-1:0]          busy_cnt;
        logic                   pend;
        logic [7:0]             pbyte;
        logic                   cancel;
    } st_t;

    st_t q, d;

    always_comb begin
        logic rise, fall, cs_fall, cs_rise, busy_v;
        logic [7:0] rx_v, status_v;
        d       = q;
        mem_we  = 1'b0;
        rise    = sck_s & ~q.sck_p;
        fall    = ~sck_s & q.sck_p;
        cs_fall = ~cs_s & q.cs_p;
        cs_rise = cs_s & ~q.cs_p;
        busy_v  = (q.busy_cnt != '0);
        status_v = {q.wpen, 5'b0, q.wel, busy_v};
        rx_v    = {q.sh, mosi_s};
        d.sck_p = sck_s;
        d.cs_p  = cs_s;
        if (busy_v) d.busy_cnt = q.busy_cnt - 1'b1;

        if (cs_s) begin
            if (cs_rise && q.phase == PH_DATA && q.bitcnt == 3'd0 && q.pend && q.wel) begin
                if (q.cmd == CMD_WRIT) begin
                    mem_we     = 1'b1;
                    d.wel      = 1'b0;
                    d.busy_cnt = CW'(BUSY_CYCLES);
                end else if (q.cmd == CMD_WRSR && !q.cancel && !(!wp_s && q.wpen)) begin
                    d.wpen     = q.pbyte[7];
                    d.wel      = 1'b0;
                    d.busy_cnt = CW'(BUSY_CYCLES);
                end
            end
            d.phase  = PH_IDLE;
            d.held   = 1'b0;
            d.pend   = 1'b0;
            d.cancel = 1'b0;
            d.bitcnt = '0;
            d.load   = 1'b0;
        end else if (cs_fall) begin
            d.phase  = PH_OPC;
            d.cmd    = CMD_NONE;
            d.bitcnt = '0;
            d.abyte  = 1'b0;
            d.held   = 1'b0;
            d.pend   = 1'b0;
            d.cancel = 1'b0;
            d.load   = 1'b0;
        end else if (q.phase != PH_IDLE && q.phase != PH_LOCK) begin
            if (!sck_s) d.held = ~hold_s;
            if (q.cmd == CMD_WRSR && q.phase == PH_DATA && !wp_s && q.wpen) d.cancel = 1'b1;
            if (q.load) begin
                d.load = 1'b0;
                d.osr  = (q.cmd == CMD_READ) ? mem_rdata : status_v;
            end
            if (!q.held && rise) begin
                d.sh     = rx_v[6:0];
                d.bitcnt = q.bitcnt + 3'd1;
                if (q.bitcnt == 3'd7) begin
                    unique case (q.phase)
                        PH_OPC: begin
                            if (busy_v && rx_v != OP_RDSR) begin
                                d.phase = PH_LOCK;
                            end else begin
                                unique case (rx_v)
                                    OP_WREN: begin d.wel = 1'b1; d.phase = PH_DATA; end
                                    OP_WRDI: begin d.wel = 1'b0; d.phase = PH_DATA; end
                                    OP_RDSR: begin d.cmd = CMD_RDSR; d.phase = PH_DATA; d.load = 1'b1; end
                                    OP_WRSR: begin d.cmd = CMD_WRSR; d.phase = PH_DATA; end
                                    OP_READ: begin d.cmd = CMD_READ; d.phase = PH_ADDR; end
                                    OP_WRIT: begin d.cmd = CMD_WRIT; d.phase = PH_ADDR; end
                                    default: d.phase = PH_LOCK;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (!q.abyte) begin
                                d.addr[15:8] = rx_v;
                                d.abyte      = 1'b1;
                            end else begin
                                d.addr[7:0] = rx_v;
                                d.phase     = PH_DATA;
                                d.load      = (q.cmd == CMD_READ);
                            end
                        end
                        PH_DATA: begin
                            if (q.cmd == CMD_WRIT || q.cmd == CMD_WRSR) begin
                                d.pbyte = rx_v;
                                d.pend  = 1'b1;
                            end else if (q.cmd == CMD_READ) begin
                                d.addr = q.addr + 1'b1;
                                d.load = 1'b1;
                            end else if (q.cmd == CMD_RDSR) begin
                                d.load = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (!q.held && fall) begin
                d.miso = q.osr[7];
                d.osr  = {q.osr[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.cmd   <= CMD_NONE;
            q.cs_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mem_waddr = q.addr[MW-1:0];
    assign mem_wdata = q.pbyte;
    assign mem_raddr = q.addr[MW-1:0];
    assign miso      = q.miso;
    assign miso_oe   = (q.phase == PH_DATA) && (q.cmd == CMD_READ || q.cmd == CMD_RDSR) && !q.held;
    assign held      = q.held;
    assign locked    = (q.phase == PH_LOCK);
    assign busy      = (q.busy_cnt != '0);
    assign wel       = q.wel;
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave #(
    parameter int DEPTH = 64,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2,
    localparam int MW = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic spi_hold_n,
    input  logic spi_wp_n,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic [4:0]    pins_s;
    logic          sck_s, cs_s, mosi_s, hold_s, wp_s;
    logic          mem_we;
    logic [MW-1:0] mem_waddr, mem_raddr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          miso_q, oe, held, locked, busy, wel;

    spimem_sync #(.STAGES(SYNC_STAGES), .N(5), .RST_VAL(5'b11010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_wp_n, spi_hold_n, spi_mosi, spi_cs_n, spi_sck}),
        .sync_o (pins_s)
    );
    assign {wp_s, hold_s, mosi_s, cs_s, sck_s} = pins_s;

    spimem_array #(.DEPTH(DEPTH)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    spimem_core #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .cs_s     (cs_s),
        .mosi_s   (mosi_s),
        .hold_s   (hold_s),
        .wp_s     (wp_s),
        .mem_rdata(mem_rdata),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr),
        .miso     (miso_q),
        .miso_oe  (oe),
        .held     (held),
        .locked   (locked),
        .busy     (busy),
        .wel      (wel)
    );

    assign spi_miso_oe = oe;
    assign spi_miso    = oe ? miso_q : 1'b0;
endmodule

// File: rtl/spimem_chk.sv
module spimem_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sck_s,
    input logic held,
    input logic locked,
    input logic busy,
    input logic wel,
    input logic oe,
    input logic miso_q
);
    logic cs_d, cs_dd, sck_d, sck_dd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d <= 1'b1; cs_dd <= 1'b1; sck_d <= 1'b0; sck_dd <= 1'b0;
        end else begin
            cs_d <= cs_s; cs_dd <= cs_d; sck_d <= sck_s; sck_dd <= sck_d;
        end
    end

    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) |-> !oe);
    a_r9_quiet_held: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !oe);
    a_r9_hold_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> ($past(!sck_s) || $past(cs_s)));
    a_r8_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cs_s) |=> locked);
    a_r6_busy_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cs_d && !cs_dd));
    a_r6_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel);
    a_r4_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_q) |-> (!sck_d && sck_dd));
endmodule

bind spimem_slave spimem_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_s  (cs_s),
    .sck_s (sck_s),
    .held  (held),
    .locked(locked),
    .busy  (busy),
    .wel   (wel),
    .oe    (oe),
    .miso_q(miso_q)
);

// File: tb/sim_spimem_slave.sv
module sim_spimem_slave;
    localparam int HP   = 8;
    localparam int BUSY = 2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic miso, oe;

    always #10 clk = ~clk;

    spimem_slave #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(oe)
    );

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic oe_seen = 1'b0;
    int mcnt = 0;
    logic [7:0] msh = '0;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: assembles output bytes and compares against the scoreboard queue
    always @(posedge sck or posedge cs_n) begin
        if (oe) oe_seen = 1'b1;
        if (cs_n) mcnt = 0;
        else if (oe) begin
            msh = {msh[6:0], miso};
            mcnt++;
            if (mcnt == 8) begin
                mcnt = 0;
                if (exp_q.size() == 0) chk(0, "unexpected byte", msh, 8'hxx);
                else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(msh === e, t, msh, e);
                end
            end
        end
    end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask
    task automatic expect_b(input logic [7:0] b, input string t); exp_q.push_back(b); tag_q.push_back(t); endtask
    task automatic sbit(input logic b); mosi = b; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0; endtask
    task automatic sbyte(input logic [7:0] b); for (int i = 7; i >= 0; i--) sbit(b[i]); endtask
    task automatic sel(); cs_n = 1'b0; tick(6); endtask
    task automatic desel(); tick(6); cs_n = 1'b1; tick(8); endtask
    task automatic op(input logic [7:0] b); sel(); sbyte(b); desel(); endtask
    task automatic rdsr(input logic [7:0] e, input string t); sel(); sbyte(8'h05); expect_b(e, t); sbyte(8'h00); desel(); endtask
    task automatic wr1(input logic [15:0] a, input logic [7:0] v);
        sel(); sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]); sbyte(v); desel();
    endtask
    task automatic rd(input logic [15:0] a, input int n, input logic [7:0] e0, input logic [7:0] e1, input string t);
        sel(); sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
        expect_b(e0, t); if (n > 1) expect_b(e1, t);
        for (int i = 0; i < n; i++) sbyte(8'h00);
        desel();
    endtask
    task automatic wrsr(input logic [7:0] v); sel(); sbyte(8'h01); sbyte(v); desel(); endtask
    task automatic wait_busy(); tick(BUSY + 100); endtask

    initial begin
        tick(5); rst_n = 1'b1; tick(5);
        chk(oe === 1'b0, "R1 reset oe", {7'b0, oe}, 8'h00);
        rdsr(8'h00, "R2 reset status");

        op(8'h06); rdsr(8'h02, "R3 wren sets wel");
        op(8'h04); rdsr(8'h00, "R3 wrdi clears wel");

        wr1(16'h0005, 8'hA5); rd(16'h0005, 1, 8'h00, 8'h00, "R5 no write without wel");

        op(8'h06); wr1(16'h0005, 8'hA5);
        rdsr(8'h01, "R6 busy set, wel cleared");
        op(8'h06); wait_busy();
        rdsr(8'h00, "R7 wren ignored while busy");
        rd(16'h0005, 1, 8'hA5, 8'h00, "R4 read back");

        op(8'h06); wr1(16'h0006, 8'h3C); wait_busy();
        rd(16'h0005, 2, 8'hA5, 8'h3C, "R4 address increments");
        rd(16'hFF45, 1, 8'hA5, 8'h00, "R4 upper address bits ignored");

        op(8'h06);
        sel(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h07); sbyte(8'h77); sbit(1); sbit(0); sbit(1); desel();
        wait_busy();
        rd(16'h0007, 1, 8'h00, 8'h00, "R5 off-boundary deselect aborts");
        rdsr(8'h02, "R5 wel kept after abort");
        op(8'h04);

        oe_seen = 1'b0;
        sel(); sbyte(8'hFF); sbyte(8'h06); sbyte(8'h05); sbyte(8'h00); desel();
        chk(oe_seen === 1'b0, "R8 output silent after invalid opcode", {7'b0, oe_seen}, 8'h00);
        rdsr(8'h00, "R8 bytes after invalid opcode ignored");

        oe_seen = 1'b0;
        for (int i = 0; i < 3; i++) sbyte(8'h06);
        chk(oe_seen === 1'b0, "R1 output silent while deselected", {7'b0, oe_seen}, 8'h00);
        rdsr(8'h00, "R1 deselected activity ignored");

        sel(); sbyte(8'h03); sbyte(8'h00); sbyte(8'h05);
        expect_b(8'hA5, "R9 read across hold"); expect_b(8'h3C, "R9 read after hold");
        sbit(0); sbit(0); sbit(0);
        tick(HP); hold_n = 1'b0; tick(6);
        chk(oe === 1'b0, "R9 oe low while held", {7'b0, oe}, 8'h00);
        for (int i = 0; i < 3; i++) begin mosi = i[0]; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0; end
        chk(oe === 1'b0, "R9 oe low during held clocks", {7'b0, oe}, 8'h00);
        tick(HP); hold_n = 1'b1; tick(6);
        for (int i = 0; i < 5; i++) sbit(0);
        sbyte(8'h00); desel();

        wp_n = 1'b0;
        op(8'h06); wrsr(8'h80); wait_busy();
        rdsr(8'h80, "R11 pin ignored when wpen clear");
        op(8'h06); wrsr(8'h00); wait_busy();
        rdsr(8'h82, "R10 status write blocked by pin");
        wp_n = 1'b1;
        sel(); sbyte(8'h01); sbit(0); sbit(0); wp_n = 1'b0; tick(20); wp_n = 1'b1;
        for (int i = 0; i < 6; i++) sbit(0);
        desel(); wait_busy();
        rdsr(8'h82, "R12 protect pulse cancels status write");
        wrsr(8'h00); wait_busy();
        rdsr(8'h00, "R10 status write with pin high");
        wrsr(8'h80); wait_busy();
        rdsr(8'h00, "R10 status write needs wel");

        tick(20);
        if (exp_q.size() != 0) chk(0, "scoreboard leftover", 8'(exp_q.size()), 8'h00);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(150000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule